// File: doc/BRIEF.md
# Audio Sample FIFO and DMA Request Controller

This block sits between a register bus, a DMA engine and a pair of audio serializers. It holds one sample FIFO per direction. Bus writes to a data register fill the transmit FIFO, and the transmit serializer drains it. The receive serializer fills the receive FIFO, and bus reads of a second data register drain it. The block raises one DMA request line per direction, based on that FIFO's fill level compared against a threshold that software programs.

Both serializers share one run control, so transmit and receive always start together. Software holds one start bit per direction. The shared run control stays on while either bit is set and turns off only once both are cleared. A clear register flushes either FIFO or both. A handshake with the serial clock domain carries the flush: the block raises a flush request and waits for an acknowledge, which it synchronises. Each clear bit reads back as 1 until the acknowledge has risen and then fallen again.

The design is built from two state machines. The link machine has the states LINK_IDLE and LINK_RUN. It goes from LINK_IDLE to LINK_RUN when any start bit is set, and from LINK_RUN back to LINK_IDLE when both start bits are clear. The flush machine has the states FL_IDLE, FL_ASSERT and FL_RELEASE. It goes from FL_IDLE to FL_ASSERT when a nonzero clear write is accepted. It goes from FL_ASSERT to FL_RELEASE when the synchronised acknowledge is high, and from FL_RELEASE back to FL_IDLE when the synchronised acknowledge is low.

Top module: `audio_xfer_ctrl`

## Requirements
- R1: After reset, the DMA control register (address 0) reads 0x001F0000, and the start (1), clear (2) and level (3) registers read 0. xfer_run, both DMA requests and ser_flush are low.
- R2: The DMA control register has these fields: transmit threshold in bits [4:0], transmit DMA enable in bit 8, receive threshold in bits [20:16], receive DMA enable in bit 24. All other bits read as 0.
- R3: tx_dma_req is high exactly when the transmit enable is set and the transmit FIFO count is less than or equal to the transmit threshold.
- R4: rx_dma_req is high exactly when the receive enable is set and the receive FIFO count is strictly greater than the receive threshold.
- R5: Each write to the transmit data register (address 4) pushes one 32-bit word. ser_tx_data presents words in write order, and ser_tx_pop removes one word per cycle. A write to a full FIFO (32 words) is dropped.
- R6: A read of the receive data register (address 5) returns the oldest received word and removes it, with the data on reg_rdata one cycle after the read strobe. A read of an empty FIFO returns 0 and changes nothing. A push from ser_rx_push into a full FIFO is dropped.
- R7: The level register holds the transmit count in bits [5:0] and the receive count in bits [13:8].
- R8: Writing a start value with bit 0 (transmit) or bit 1 (receive) set raises xfer_run for both serializers on the second clock edge after the write. The register reads back the value written.
- R9: xfer_run stays high while either start bit is set, and falls only after both bits have been written 0.
- R10: Writing 1 to clear bit 0 empties the transmit FIFO, and writing 1 to clear bit 1 empties the receive FIFO. ser_flush then shows the chosen bits toward the serial domain.
- R11: Clear bits read 1 until ser_flush_ack has risen and then fallen, and read 0 after that. A clear write made while a flush is in progress is ignored.
- R12: While a direction is being flushed, pushes into that direction's FIFO are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| xfer_run | output | 1 | Shared run control to both serializers |
| ser_tx_pop | input | 1 | Transmit serializer takes one word |
| ser_tx_data | output | 32 | Oldest transmit word |
| ser_tx_empty | output | 1 | Transmit FIFO is empty |
| ser_rx_push | input | 1 | Receive serializer delivers one word |
| ser_rx_data | input | 32 | Received word |
| ser_flush | output | 2 | Flush request to the serial domain, bit 0 transmit, bit 1 receive |
| ser_flush_ack | input | 1 | Flush acknowledge from the serial domain, asynchronous |

## Verification
The checks assume the following about the inputs:
- ser_flush_ack rises only after ser_flush has been raised, and falls only after ser_flush has dropped.
- The serializer pops the transmit FIFO only while ser_tx_empty is low.
- Bus strobes are single-cycle and never select two registers at once.

The stimulus respects these rules. It models the serial side as a four-cycle delay from ser_flush to ser_flush_ack, and it pops only as many words as the scoreboard holds. It also drives every input one time unit after the rising edge, so the synchroniser samples a stable acknowledge.

// File: rtl/axc_pkg.sv
package axc_pkg;
    localparam int REG_W        = 32;
    localparam int ADDR_W       = 3;

    localparam logic [ADDR_W-1:0] A_DMA    = 3'd0;
    localparam logic [ADDR_W-1:0] A_START  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TXDATA = 3'd4;
    localparam logic [ADDR_W-1:0] A_RXDATA = 3'd5;

    localparam int TX_THR_LSB = 0;
    localparam int TX_EN_BIT  = 8;
    localparam int RX_THR_LSB = 16;
    localparam int RX_EN_BIT  = 24;
    localparam int RX_LVL_LSB = 8;

    typedef enum logic {
        LINK_IDLE,
        LINK_RUN
    } link_state_t;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_ASSERT,
        FL_RELEASE
    } flush_state_t;
endpackage

// File: rtl/axc_fifo.sv
module axc_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign do_push = push && !flush && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && !flush && (count != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/axc_dma_req.sv
module axc_dma_req #(
    parameter int CNT_W = 6,
    parameter int THR_W = 5,
    parameter bit ABOVE = 1'b0
) (
    input  logic             en,
    input  logic [CNT_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    output logic             req
);
    logic [CNT_W-1:0] thr_ext;
    assign thr_ext = CNT_W'(thr);

    generate
        if (ABOVE) begin : g_fill_side
            assign req = en && (level > thr_ext);
        end else begin : g_drain_side
            assign req = en && (level <= thr_ext);
        end
    endgenerate
endmodule

// File: rtl/axc_link_fsm.sv
module axc_link_fsm
    import axc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] start_bits,
    output logic       run
);
    link_state_t state_q;
    link_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINK_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LINK_IDLE: if (start_bits != 2'b00) state_nx = LINK_RUN;
            LINK_RUN:  if (start_bits == 2'b00) state_nx = LINK_IDLE;
            default:   state_nx = LINK_IDLE;
        endcase
    end

    always_comb begin
        run = 1'b0;
        unique case (state_q)
            LINK_IDLE: run = 1'b0;
            LINK_RUN:  run = 1'b1;
            default:   run = 1'b0;
        endcase
    end
endmodule

// File: rtl/axc_flush_fsm.sv
module axc_flush_fsm
    import axc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    input  logic       ack_async,
    output logic [1:0] pend,
    output logic [1:0] flush_req,
    output logic [1:0] flush_hold,
    output logic       ack_sync
);
    flush_state_t            state_q;
    flush_state_t            state_nx;
    logic [SYNC_STAGES-1:0]  sync_q;
    logic                    accept;

    assign ack_sync = sync_q[SYNC_STAGES-1];
    assign accept   = clr_wr && (state_q == FL_IDLE) && (clr_bits != 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ack_async};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FL_IDLE:    if (accept)    state_nx = FL_ASSERT;
            FL_ASSERT:  if (ack_sync)  state_nx = FL_RELEASE;
            FL_RELEASE: if (!ack_sync) state_nx = FL_IDLE;
            default:    state_nx = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 2'b00;
        end else if (accept) begin
            pend <= clr_bits;
        end else if (state_q == FL_RELEASE && !ack_sync) begin
            pend <= 2'b00;
        end
    end

    always_comb begin
        flush_req  = 2'b00;
        flush_hold = pend;
        unique case (state_q)
            FL_IDLE:    flush_hold = accept ? clr_bits : 2'b00;
            FL_ASSERT:  flush_req  = pend;
            FL_RELEASE: flush_req  = 2'b00;
            default:    flush_req  = 2'b00;
        endcase
    end
endmodule

// File: rtl/audio_xfer_ctrl.sv
module audio_xfer_ctrl
    import axc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEPTH) + 1,
    localparam int THR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              xfer_run,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    output logic              ser_tx_empty,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    output logic [1:0]        ser_flush,
    input  logic              ser_flush_ack
);
    logic [THR_W-1:0]  tx_thr_q;
    logic [THR_W-1:0]  rx_thr_q;
    logic              tx_en_q;
    logic              rx_en_q;
    logic [1:0]        st_q;
    logic [REG_W-1:0]  rdata_q;
    logic [REG_W-1:0]  rd_mux;
    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  rx_cnt;
    logic [DATA_W-1:0] rx_head;
    logic [1:0]        pend;
    logic [1:0]        flush_hold;
    logic              ack_s;
    logic              wr_dma;
    logic              wr_start;
    logic              wr_clear;
    logic              wr_txdata;
    logic              rd_rxdata;

    assign wr_dma    = reg_wr && (reg_addr == A_DMA);
    assign wr_start  = reg_wr && (reg_addr == A_START);
    assign wr_clear  = reg_wr && (reg_addr == A_CLEAR);
    assign wr_txdata = reg_wr && (reg_addr == A_TXDATA);
    assign rd_rxdata = reg_rd && (reg_addr == A_RXDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= THR_W'(DEPTH - 1);
            tx_en_q  <= 1'b0;
            rx_en_q  <= 1'b0;
            st_q     <= 2'b00;
        end else begin
            if (wr_dma) begin
                tx_thr_q <= reg_wdata[TX_THR_LSB +: THR_W];
                rx_thr_q <= reg_wdata[RX_THR_LSB +: THR_W];
                tx_en_q  <= reg_wdata[TX_EN_BIT];
                rx_en_q  <= reg_wdata[RX_EN_BIT];
            end
            if (wr_start) begin
                st_q <= reg_wdata[1:0];
            end
        end
    end

    axc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_hold[0]),
        .push      (wr_txdata),
        .push_data (reg_wdata[DATA_W-1:0]),
        .pop       (ser_tx_pop),
        .head      (ser_tx_data),
        .count     (tx_cnt)
    );

    axc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_hold[1]),
        .push      (ser_rx_push),
        .push_data (ser_rx_data),
        .pop       (rd_rxdata),
        .head      (rx_head),
        .count     (rx_cnt)
    );

    axc_dma_req #(.CNT_W(CNT_W), .THR_W(THR_W), .ABOVE(1'b0)) u_tx_req (
        .en    (tx_en_q),
        .level (tx_cnt),
        .thr   (tx_thr_q),
        .req   (tx_dma_req)
    );

    axc_dma_req #(.CNT_W(CNT_W), .THR_W(THR_W), .ABOVE(1'b1)) u_rx_req (
        .en    (rx_en_q),
        .level (rx_cnt),
        .thr   (rx_thr_q),
        .req   (rx_dma_req)
    );

    axc_link_fsm u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_bits (st_q),
        .run        (xfer_run)
    );

    axc_flush_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_wr     (wr_clear),
        .clr_bits   (reg_wdata[1:0]),
        .ack_async  (ser_flush_ack),
        .pend       (pend),
        .flush_req  (ser_flush),
        .flush_hold (flush_hold),
        .ack_sync   (ack_s)
    );

    assign ser_tx_empty = (tx_cnt == '0);

    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_DMA: begin
                rd_mux[TX_THR_LSB +: THR_W] = tx_thr_q;
                rd_mux[RX_THR_LSB +: THR_W] = rx_thr_q;
                rd_mux[TX_EN_BIT]           = tx_en_q;
                rd_mux[RX_EN_BIT]           = rx_en_q;
            end
            A_START:  rd_mux[1:0] = st_q;
            A_CLEAR:  rd_mux[1:0] = pend;
            A_LEVEL: begin
                rd_mux[0 +: CNT_W]          = tx_cnt;
                rd_mux[RX_LVL_LSB +: CNT_W] = rx_cnt;
            end
            A_RXDATA: if (rx_cnt != '0) rd_mux[DATA_W-1:0] = rx_head;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/axc_checker.sv
module axc_checker #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6,
    parameter int THR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [THR_W-1:0] tx_thr_q,
    input logic [THR_W-1:0] rx_thr_q,
    input logic             tx_dma_req,
    input logic             rx_dma_req,
    input logic [1:0]       st_q,
    input logic             xfer_run,
    input logic [1:0]       ser_flush,
    input logic [1:0]       pend,
    input logic             ack_s
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH))); // R5

    AST_TX_REQ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt > CNT_W'(tx_thr_q)) |-> !tx_dma_req); // R3

    AST_RX_REQ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CNT_W'(rx_thr_q)) |-> !rx_dma_req); // R4

    AST_RUN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_run) |-> $past(st_q != 2'b00)); // R8

    AST_RUN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_run) |-> $past(st_q == 2'b00)); // R9

    AST_TX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        ser_flush[0] |-> (tx_cnt == '0)); // R10

    AST_RX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        ser_flush[1] |-> (rx_cnt == '0)); // R12

    AST_CLEAR_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend != 2'b00) |-> !$past(ack_s)); // R11
endmodule

bind audio_xfer_ctrl axc_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .tx_thr_q   (tx_thr_q),
    .rx_thr_q   (rx_thr_q),
    .tx_dma_req (tx_dma_req),
    .rx_dma_req (rx_dma_req),
    .st_q       (st_q),
    .xfer_run   (xfer_run),
    .ser_flush  (ser_flush),
    .pend       (pend),
    .ack_s      (ack_s)
);

// File: tb/audio_xfer_ctrl_test.sv
module audio_xfer_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_dma_req;
    logic        rx_dma_req;
    logic        xfer_run;
    logic        ser_tx_pop = 1'b0;
    logic [31:0] ser_tx_data;
    logic        ser_tx_empty;
    logic        ser_rx_push = 1'b0;
    logic [31:0] ser_rx_data = '0;
    logic [1:0]  ser_flush;
    logic        ser_flush_ack;
    logic [3:0]  ack_dly = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] exp_tx[$];
    logic [31:0] exp_rx[$];

    always #5 clk = ~clk;

    audio_xfer_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .tx_dma_req    (tx_dma_req),
        .rx_dma_req    (rx_dma_req),
        .xfer_run      (xfer_run),
        .ser_tx_pop    (ser_tx_pop),
        .ser_tx_data   (ser_tx_data),
        .ser_tx_empty  (ser_tx_empty),
        .ser_rx_push   (ser_rx_push),
        .ser_rx_data   (ser_rx_data),
        .ser_flush     (ser_flush),
        .ser_flush_ack (ser_flush_ack)
    );

    // serial-side responder: acknowledge follows the flush request after four cycles
    always @(posedge clk) ack_dly <= {ack_dly[2:0], |ser_flush};
    assign ser_flush_ack = ack_dly[3];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push_tx(input logic [31:0] d);
        wr(3'd4, d);
        if (exp_tx.size() < 32) exp_tx.push_back(d);
    endtask

    task automatic push_rx(input logic [31:0] d, input bit dropped);
        @(posedge clk); #1;
        ser_rx_push = 1'b1; ser_rx_data = d;
        @(posedge clk); #1;
        ser_rx_push = 1'b0;
        if (!dropped && exp_rx.size() < 32) exp_rx.push_back(d);
    endtask

    task automatic drain_tx(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ser_tx_pop = 1'b1;
        end
        @(posedge clk); #1;
        ser_tx_pop = 1'b0;
    endtask

    task automatic read_rx(input string req);
        logic [31:0] v;
        logic [31:0] e;
        e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 32'h0;
        rd(3'd5, v);
        check(req, v, e);
    endtask

    task automatic wait_clear_done(input string req);
        logic [31:0] v;
        bit done = 1'b0;
        for (int i = 0; i < 60 && !done; i++) begin
            rd(3'd2, v);
            if (v == 32'h0) done = 1'b1;
        end
        check(req, {31'h0, done}, 32'h1);
    endtask

    // monitor: compares every word taken by the serializer against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ser_tx_pop) begin
            if (exp_tx.size() == 0) check("R5 unexpected pop", ser_tx_data, 32'hDEAD_BEEF);
            else check("R5 tx word order", ser_tx_data, exp_tx.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 dma reset", v, 32'h001F_0000);
        rd(3'd1, v); check("R1 start reset", v, 32'h0);
        rd(3'd2, v); check("R1 clear reset", v, 32'h0);
        rd(3'd3, v); check("R1 level reset", v, 32'h0);
        check("R1 outputs", {28'h0, xfer_run, tx_dma_req, rx_dma_req, |ser_flush}, 32'h0);

        // R2 field layout
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R2 all ones", v, 32'h011F_011F);
        wr(3'd0, 32'h0110_0110);
        rd(3'd0, v); check("R2 thresholds 16", v, 32'h0110_0110);

        // R3 transmit request threshold
        check("R3 empty", {31'h0, tx_dma_req}, 32'h1);
        for (int i = 0; i < 16; i++) push_tx(32'hA000_0000 + i);
        check("R3 at threshold", {31'h0, tx_dma_req}, 32'h1);
        push_tx(32'hA000_0010);
        check("R3 above threshold", {31'h0, tx_dma_req}, 32'h0);
        rd(3'd3, v); check("R7 tx level 17", v, 32'd17);

        // R5 fill to full, overflow dropped, drain in order
        for (int i = 17; i < 34; i++) push_tx(32'hA000_0000 + i);
        rd(3'd3, v); check("R5 tx full level", v, 32'd32);
        drain_tx(32);
        rd(3'd3, v); check("R5 tx drained", v, 32'd0);
        check("R5 empty flag", {31'h0, ser_tx_empty}, 32'h1);

        // R6 / R4 receive path
        read_rx("R6 empty read");
        rd(3'd3, v); check("R6 empty read no change", v, 32'd0);
        for (int i = 0; i < 16; i++) push_rx(32'hB000_0000 + i, 1'b0);
        check("R4 at threshold", {31'h0, rx_dma_req}, 32'h0);
        push_rx(32'hB000_0010, 1'b0);
        check("R4 above threshold", {31'h0, rx_dma_req}, 32'h1);
        rd(3'd3, v); check("R7 rx level 17", v, 32'd17 << 8);
        for (int i = 17; i < 34; i++) push_rx(32'hB000_0000 + i, 1'b0);
        rd(3'd3, v); check("R6 rx full level", v, 32'd32 << 8);
        for (int i = 0; i < 32; i++) read_rx("R6 rx word order");
        rd(3'd3, v); check("R6 rx drained", v, 32'd0);
        check("R4 empty", {31'h0, rx_dma_req}, 32'h0);

        // R8 / R9 shared run control
        wr(3'd1, 32'h2);
        check("R8 not before second edge", {31'h0, xfer_run}, 32'h0);
        @(posedge clk); #1;
        check("R8 run raised by rx bit", {31'h0, xfer_run}, 32'h1);
        rd(3'd1, v); check("R8 start readback", v, 32'h2);
        wr(3'd1, 32'h1);
        repeat (3) @(posedge clk); #1;
        check("R9 run held by tx bit", {31'h0, xfer_run}, 32'h1);
        wr(3'd1, 32'h0);
        check("R9 still high one edge", {31'h0, xfer_run}, 32'h1);
        @(posedge clk); #1;
        check("R9 run dropped", {31'h0, xfer_run}, 32'h0);

        // R10 / R11 transmit flush, busy write ignored
        for (int i = 0; i < 3; i++) push_tx(32'hC000_0000 + i);
        for (int i = 0; i < 3; i++) push_rx(32'hD000_0000 + i, 1'b0);
        wr(3'd2, 32'h1);
        exp_tx.delete();
        rd(3'd2, v); check("R11 clear busy", v, 32'h1);
        wr(3'd2, 32'h2);
        check("R10 flush request", {30'h0, ser_flush}, 32'h1);
        rd(3'd2, v); check("R11 busy write ignored", v, 32'h1);
        rd(3'd3, v); check("R10 tx emptied rx kept", v, 32'd3 << 8);
        wait_clear_done("R11 clear self-clears");
        check("R11 flush request dropped", {30'h0, ser_flush}, 32'h0);
        rd(3'd3, v); check("R11 rx untouched", v, 32'd3 << 8);

        // R12 pushes during receive flush discarded
        wr(3'd2, 32'h2);
        exp_rx.delete();
        push_rx(32'hE000_0001, 1'b1);
        push_rx(32'hE000_0002, 1'b1);
        rd(3'd3, v); check("R12 no push during flush", v, 32'd0);
        wait_clear_done("R11 receive clear done");
        push_rx(32'hF000_0000, 1'b0);
        read_rx("R12 receive resumes after flush");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule